// File: doc/BRIEF.md
# Command Start Handshake Unit

This unit sits between the software-visible command registers of a card host controller and the logic that runs in the card clock domain. Software loads a command word and a 32-bit argument and sets the start bit. The start bit reads back as 1 while the request is outstanding. It drops when the card-interface side accepts the request, after a fixed synchronisation delay. A request flagged as update-clock is not sent as a command. Instead, on acceptance it copies the staged divider, clock-source and enable values into the active clock registers. A request flagged as wait-for-previous holds off acceptance for as long as the card reports busy.

If software writes a new request while one is still outstanding, the new request is dropped and a sticky hardware-locked error flag is raised. Software must then clear the flag and retry. The unit also holds three self-clearing reset bits: controller, FIFO and DMA. A write to the controller reset bit aborts any outstanding request.

Top module: `cmd_start_ctrl`

## Requirements
- R1: After reset, start_bit, hle, issue_vld and clk_load are 0, the active clock outputs are 0 and all reset bits are 0.
- R2: A command write while idle makes start_bit read 1 from the next cycle. start_bit clears SYNC_CYC clock edges after the write edge, at the edge where issue_vld rises for exactly one cycle.
- R3: The index, card number and argument presented with the request are the values on the inputs at the write edge. Later changes to those inputs have no effect on the issued values.
- R4: A request with the wait-for-previous flag set does not advance toward acceptance while card_busy is 1. A request without the flag ignores card_busy.
- R5: An update-clock request produces no issue_vld. At acceptance, clk_load pulses for one cycle and the active divider, source and enable take the staged values present at that edge.
- R6: The active clock outputs do not change except at acceptance of an update-clock request, whatever the staged inputs do.
- R7: A command write while a request is outstanding sets hle and is dropped. The outstanding request is accepted once, with its own fields.
- R8: hle stays 1 until a cycle with hle_clr high. If a new collision happens in the same cycle, setting wins.
- R9: A write with bit 0 (controller), bit 1 (FIFO) or bit 2 (DMA) of rst_wr set sets that reset bit. The bit reads 1 for RST_CYC cycles and then clears itself.
- R10: A write of rst_wr bit 0 drops any outstanding request with no acceptance and clears hle in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write with start bit set |
| cmd_idx | input | 6 | Command index |
| cmd_card | input | 2 | Card number field |
| cmd_upd_clk | input | 1 | Update-clock-only request flag |
| cmd_wait_prev | input | 1 | Wait until card not busy before accepting |
| cmd_arg | input | 32 | Command argument |
| card_busy | input | 1 | Card reports busy |
| stg_div | input | 8 | Staged clock divider |
| stg_src | input | 2 | Staged clock source select |
| stg_ena | input | 1 | Staged clock enable |
| hle_clr | input | 1 | Clear the hardware-locked error flag |
| rst_wr | input | 3 | Reset-bit set strobes (0 controller, 1 FIFO, 2 DMA) |
| start_bit | output | 1 | Start bit readback, 1 while a request is outstanding |
| hle | output | 1 | Sticky hardware-locked error flag |
| issue_vld | output | 1 | One-cycle strobe: command accepted for the bus |
| issue_idx | output | 6 | Accepted command index |
| issue_card | output | 2 | Accepted card number |
| issue_arg | output | 32 | Accepted argument |
| clk_load | output | 1 | One-cycle strobe: clock settings loaded |
| act_div | output | 8 | Active clock divider |
| act_src | output | 2 | Active clock source select |
| act_ena | output | 1 | Active clock enable |
| rst_bits | output | 3 | Reset bits readback |

## Verification
A stuck or miscounted synchronisation counter shows on start_bit and issue_vld: the strobe appears early, late or never, within SYNC_CYC cycles of the write. A request register that reloads while busy shows as wrong fields on issue_idx or issue_arg, or as a second strobe, a few cycles after a collision. A wrongly gated load shows at once on act_div after a staged-value change. Reset-bit counting faults show on rst_bits within RST_CYC cycles.

// File: rtl/cmdh_pkg.sv
package cmdh_pkg;
    localparam int IDX_W  = 6;
    localparam int CARD_W = 2;
    localparam int ARG_W  = 32;
    localparam int DIV_W  = 8;
    localparam int NUM_RST = 3;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [CARD_W-1:0] card;
        logic              upd_clk;
        logic              wait_prev;
    } cmd_word_t;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [CARD_W-1:0] src;
        logic              ena;
    } clk_cfg_t;

    typedef enum int {
        RB_CTRL = 0,
        RB_FIFO = 1,
        RB_DMA  = 2
    } rst_bit_e;

    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/cmdh_accept.sv
module cmdh_accept
    import cmdh_pkg::*;
#(
    parameter int SYNC_CYC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             wr,
    input  cmd_word_t        cmd_in,
    input  logic [ARG_W-1:0] arg_in,
    input  logic             card_busy,
    output logic             pend,
    output logic             acc_now,
    output logic             fire,
    output logic             collide,
    output cmd_word_t        cmd_q,
    output logic [ARG_W-1:0] arg_q
);
    localparam int CNT_W = cnt_width(SYNC_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic             go;

    assign go      = !(cmd_q.wait_prev && card_busy);
    assign acc_now = pend && go && (cnt == LAST) && !abort;
    assign collide = wr && pend && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            cnt   <= '0;
            fire  <= 1'b0;
            cmd_q <= '0;
            arg_q <= '0;
        end else begin
            fire <= acc_now;
            if (abort) begin
                pend <= 1'b0;
                cnt  <= '0;
            end else if (wr && !pend) begin
                pend  <= 1'b1;
                cnt   <= '0;
                cmd_q <= cmd_in;
                arg_q <= arg_in;
            end else if (acc_now) begin
                pend <= 1'b0;
                cnt  <= '0;
            end else if (pend && go) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/cmdh_clkload.sv
module cmdh_clkload
    import cmdh_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  clk_cfg_t staged,
    output clk_cfg_t active
);
    always_ff @(posedge clk) begin
        if (rst)       active <= '0;
        else if (load) active <= staged;
    end
endmodule

// File: rtl/cmdh_rstbits.sv
module cmdh_rstbits #(
    parameter int NUM     = 3,
    parameter int RST_CYC = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NUM-1:0] set,
    output logic [NUM-1:0] bits
);
    localparam int CW = cmdh_pkg::cnt_width(RST_CYC);
    localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

    for (genvar i = 0; i < NUM; i++) begin : g_bit
        logic [CW-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst) begin
                bits[i] <= 1'b0;
                cnt     <= '0;
            end else if (set[i]) begin
                bits[i] <= 1'b1;
                cnt     <= '0;
            end else if (bits[i]) begin
                if (cnt == LAST) bits[i] <= 1'b0;
                else             cnt     <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/cmd_start_ctrl.sv
module cmd_start_ctrl
    import cmdh_pkg::*;
#(
    parameter int SYNC_CYC = 3,
    parameter int RST_CYC  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_wr,
    input  logic [IDX_W-1:0]   cmd_idx,
    input  logic [CARD_W-1:0]  cmd_card,
    input  logic               cmd_upd_clk,
    input  logic               cmd_wait_prev,
    input  logic [ARG_W-1:0]   cmd_arg,
    input  logic               card_busy,
    input  logic [DIV_W-1:0]   stg_div,
    input  logic [CARD_W-1:0]  stg_src,
    input  logic               stg_ena,
    input  logic               hle_clr,
    input  logic [NUM_RST-1:0] rst_wr,
    output logic               start_bit,
    output logic               hle,
    output logic               issue_vld,
    output logic [IDX_W-1:0]   issue_idx,
    output logic [CARD_W-1:0]  issue_card,
    output logic [ARG_W-1:0]   issue_arg,
    output logic               clk_load,
    output logic [DIV_W-1:0]   act_div,
    output logic [CARD_W-1:0]  act_src,
    output logic               act_ena,
    output logic [NUM_RST-1:0] rst_bits
);
    cmd_word_t cmd_in, cmd_q;
    clk_cfg_t  stg, act;
    logic      abort, acc_now, fire, collide, pend;
    logic [ARG_W-1:0] arg_q;

    assign cmd_in = '{idx: cmd_idx, card: cmd_card,
                      upd_clk: cmd_upd_clk, wait_prev: cmd_wait_prev};
    assign stg    = '{div: stg_div, src: stg_src, ena: stg_ena};
    assign abort  = rst_wr[RB_CTRL];

    cmdh_accept #(.SYNC_CYC(SYNC_CYC)) u_accept (
        .clk(clk), .rst(rst), .abort(abort), .wr(cmd_wr),
        .cmd_in(cmd_in), .arg_in(cmd_arg), .card_busy(card_busy),
        .pend(pend), .acc_now(acc_now), .fire(fire), .collide(collide),
        .cmd_q(cmd_q), .arg_q(arg_q)
    );

    cmdh_clkload u_clk (
        .clk(clk), .rst(rst), .load(acc_now && cmd_q.upd_clk),
        .staged(stg), .active(act)
    );

    cmdh_rstbits #(.NUM(NUM_RST), .RST_CYC(RST_CYC)) u_rst (
        .clk(clk), .rst(rst), .set(rst_wr), .bits(rst_bits)
    );

    always_ff @(posedge clk) begin
        if (rst || abort) hle <= 1'b0;
        else if (collide) hle <= 1'b1;
        else if (hle_clr) hle <= 1'b0;
    end

    assign start_bit  = pend;
    assign issue_vld  = fire && !cmd_q.upd_clk;
    assign clk_load   = fire && cmd_q.upd_clk;
    assign issue_idx  = cmd_q.idx;
    assign issue_card = cmd_q.card;
    assign issue_arg  = arg_q;
    assign act_div    = act.div;
    assign act_src    = act.src;
    assign act_ena    = act.ena;
endmodule

// File: rtl/cmd_start_ctrl_chk.sv
module cmd_start_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_wr,
    input logic       hle_clr,
    input logic [2:0] rst_wr,
    input logic       start_bit,
    input logic       hle,
    input logic       issue_vld,
    input logic       clk_load,
    input logic [7:0] act_div,
    input logic [2:0] rst_bits
);
    p_start_after_wr_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !start_bit && !rst_wr[0]) |=> start_bit);
    p_issue_clears_r2: assert property (@(posedge clk) disable iff (rst)
        issue_vld |-> !start_bit);
    p_issue_single_r2: assert property (@(posedge clk) disable iff (rst)
        issue_vld |=> !issue_vld);
    p_load_no_issue_r5: assert property (@(posedge clk) disable iff (rst)
        clk_load |-> !issue_vld);
    p_act_stable_r6: assert property (@(posedge clk) disable iff (rst)
        !clk_load |-> $stable(act_div));
    p_hle_set_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && start_bit && !rst_wr[0]) |=> hle);
    p_hle_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (hle && !hle_clr && !rst_wr[0]) |=> hle);
    p_fifo_bit_r9: assert property (@(posedge clk) disable iff (rst)
        rst_wr[1] |=> rst_bits[1]);
    p_abort_r10: assert property (@(posedge clk) disable iff (rst)
        rst_wr[0] |=> (!start_bit && !hle && !issue_vld));
endmodule

bind cmd_start_ctrl cmd_start_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .hle_clr(hle_clr),
    .rst_wr(rst_wr), .start_bit(start_bit), .hle(hle),
    .issue_vld(issue_vld), .clk_load(clk_load), .act_div(act_div),
    .rst_bits(rst_bits)
);

// File: tb/cmd_start_ctrl_tb.sv
module cmd_start_ctrl_tb;
    localparam int SYNC = 3;
    localparam int RCYC = 4;

    logic        clk = 1'b0, rst = 1'b1;
    logic        cmd_wr = 0, cmd_upd_clk = 0, cmd_wait_prev = 0, card_busy = 0;
    logic [5:0]  cmd_idx = '0;
    logic [1:0]  cmd_card = '0, stg_src = '0;
    logic [31:0] cmd_arg = '0;
    logic [7:0]  stg_div = '0;
    logic        stg_ena = 0, hle_clr = 0;
    logic [2:0]  rst_wr = '0;
    logic        start_bit, hle, issue_vld, clk_load, act_ena;
    logic [5:0]  issue_idx;
    logic [1:0]  issue_card, act_src;
    logic [31:0] issue_arg;
    logic [7:0]  act_div;
    logic [2:0]  rst_bits;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cmd_start_ctrl #(.SYNC_CYC(SYNC), .RST_CYC(RCYC)) u_dut (.*);

    // {idx, card, arg}
    localparam logic [39:0] VEC [5] = '{
        {6'd0,  2'd0, 32'h0000_0000},
        {6'd17, 2'd1, 32'hDEAD_BEEF},
        {6'd63, 2'd3, 32'hFFFF_FFFF},
        {6'd8,  2'd2, 32'h1234_5678},
        {6'd55, 2'd1, 32'h8000_0001}
    };

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one request; returns at the negedge just after its write edge
    task automatic issue(input logic [5:0] idx, input logic [1:0] card,
                         input logic [31:0] arg, input logic upd, input logic wt);
        @(negedge clk);
        cmd_wr = 1; cmd_idx = idx; cmd_card = card; cmd_arg = arg;
        cmd_upd_clk = upd; cmd_wait_prev = wt;
        @(negedge clk);
        cmd_wr = 0; cmd_upd_clk = 0; cmd_wait_prev = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(start_bit == 0 && hle == 0 && issue_vld == 0 && clk_load == 0,
              "R1 flags", {start_bit, hle, issue_vld, clk_load}, 0);
        check(act_div == 0 && act_src == 0 && act_ena == 0 && rst_bits == 0,
              "R1 clock/reset bits", {act_div, act_src, act_ena, rst_bits}, 0);

        // R2/R3 table walk
        for (int i = 0; i < 5; i++) begin
            issue(VEC[i][39:34], VEC[i][33:32], VEC[i][31:0], 0, 0);
            cmd_arg = ~VEC[i][31:0]; cmd_idx = ~VEC[i][39:34]; cmd_card = ~VEC[i][33:32];
            for (int k = 0; k < SYNC; k++) begin
                check(start_bit == 1 && issue_vld == 0, "R2 pending",
                      {start_bit, issue_vld}, 2'b10);
                @(negedge clk);
            end
            check(issue_vld == 1 && start_bit == 0, "R2 accept", {issue_vld, start_bit}, 2'b10);
            check({issue_idx, issue_card, issue_arg} == VEC[i], "R3 fields",
                  {issue_idx, issue_card, issue_arg}, VEC[i]);
            @(negedge clk);
            check(issue_vld == 0, "R2 single strobe", issue_vld, 0);
        end

        // R4 non-wait request ignores busy
        card_busy = 1;
        issue(6'd5, 2'd0, 32'h5, 0, 0);
        repeat (SYNC) @(negedge clk);
        check(issue_vld == 1, "R4 busy ignored", issue_vld, 1);
        // R4 wait request stalls
        issue(6'd6, 2'd1, 32'h6, 0, 1);
        for (int k = 0; k < 10; k++) begin
            check(start_bit == 1 && issue_vld == 0, "R4 stalled", {start_bit, issue_vld}, 2'b10);
            @(negedge clk);
        end
        card_busy = 0;
        @(negedge clk);
        @(negedge clk);
        check(issue_vld == 0 && start_bit == 1, "R4 counting", {issue_vld, start_bit}, 2'b01);
        @(negedge clk);
        check(issue_vld == 1 && issue_idx == 6'd6, "R4 release", {issue_vld, issue_idx}, {1'b1, 6'd6});

        // R5 update clock
        stg_div = 8'hA5; stg_src = 2'd2; stg_ena = 1;
        issue(6'd0, 2'd1, 32'h0, 1, 0);
        repeat (SYNC - 1) @(negedge clk);
        check(act_div == 0 && clk_load == 0, "R5 before load", {act_div, clk_load}, 0);
        @(negedge clk);
        check(clk_load == 1 && issue_vld == 0, "R5 load strobe", {clk_load, issue_vld}, 2'b10);
        check(act_div == 8'hA5 && act_src == 2'd2 && act_ena == 1, "R5 values",
              {act_div, act_src, act_ena}, {8'hA5, 2'd2, 1'b1});
        @(negedge clk);
        check(clk_load == 0, "R5 single strobe", clk_load, 0);
        // R6 staged changes alone do nothing
        stg_div = 8'h11; stg_src = 2'd0; stg_ena = 0;
        issue(6'd9, 2'd0, 32'h9, 0, 0);
        repeat (SYNC + 3) @(negedge clk);
        check(act_div == 8'hA5 && act_src == 2'd2 && act_ena == 1, "R6 active held",
              {act_div, act_src, act_ena}, {8'hA5, 2'd2, 1'b1});

        // R7 collision
        issue(6'd20, 2'd2, 32'hAAAA_0000, 0, 0);
        cmd_wr = 1; cmd_idx = 6'd21; cmd_card = 2'd3; cmd_arg = 32'hBBBB_0000;
        @(negedge clk);
        cmd_wr = 0;
        check(hle == 1, "R7 hle set", hle, 1);
        @(negedge clk);
        @(negedge clk);
        check(issue_vld == 1 && issue_idx == 6'd20 && issue_arg == 32'hAAAA_0000,
              "R7 original kept", {issue_vld, issue_idx, issue_arg}, {1'b1, 6'd20, 32'hAAAA_0000});
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(issue_vld == 0 && start_bit == 0, "R7 dropped", {issue_vld, start_bit}, 0);
        end
        // R8 sticky, then clear
        check(hle == 1, "R8 sticky", hle, 1);
        hle_clr = 1;
        @(negedge clk);
        hle_clr = 0;
        check(hle == 0, "R8 cleared", hle, 0);

        // R9 FIFO and DMA bits
        rst_wr = 3'b110;
        @(negedge clk);
        rst_wr = 3'b000;
        for (int k = 0; k < RCYC; k++) begin
            check(rst_bits == 3'b110, "R9 held", rst_bits, 3'b110);
            @(negedge clk);
        end
        check(rst_bits == 3'b000, "R9 self-clear", rst_bits, 3'b000);

        // R10 controller reset aborts and clears hle
        issue(6'd30, 2'd0, 32'h30, 0, 0);
        cmd_wr = 1;
        @(negedge clk);
        cmd_wr = 0;
        check(hle == 1, "R10 setup hle", hle, 1);
        rst_wr = 3'b001;
        @(negedge clk);
        rst_wr = 3'b000;
        check(start_bit == 0 && hle == 0 && rst_bits == 3'b001, "R10 abort",
              {start_bit, hle, rst_bits}, 5'b00001);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(issue_vld == 0, "R10 no accept", issue_vld, 0);
        end
        check(rst_bits == 3'b000, "R9 ctrl self-clear", rst_bits, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule